// File: doc/BRIEF.md
# Reloading Long-Word DMA Channel

This block is one DMA channel that copies 32-bit words from a peripheral's data register into memory. Software programs a source address, a destination address, a transfer count and a control word through a small register port. A pulse on the peripheral request input, for example a converter's data-ready event, starts the channel. The channel then requests the bus, and once granted it performs each transfer as a single-beat read from the source followed by a single-beat write of the same word to the destination.

The source and destination each have their own stepping mode: up by four bytes, down by four bytes, or fixed. Without reload, one request runs the whole job in burst, keeping the bus request high from the first read to the last write. With reload on, the channel works in groups of four transfers. After the fourth transfer of each group the source address returns to the value last programmed, the destination keeps stepping, and the bus request is dropped until the next peripheral request. When the count reaches zero a completion flag is set, which raises the interrupt if that is enabled. Software must clear the flag before the channel can start again.

Top module: `dmac_reload_chan`

## Requirements
- R1: After reset all four registers read as zero, and `bus_req` and `irq` are low.
- R2: A transfer run begins only on a `per_req` pulse while the enable bit (control bit 0) is 1, the completion flag is 0 and the count is nonzero. Otherwise `bus_req` stays low.
- R3: Each transfer is a read (`bus_we`=0) at the source address, then a write (`bus_we`=1) of the read word to the destination address. `bus_valid` is high only while `bus_gnt` and `bus_req` are high.
- R4: Mode codes are 2'b01 for up by 4, 2'b10 for down by 4, and 2'b00 or 2'b11 for fixed. Source mode is control bits [4:3] and destination mode is bits [6:5], chosen independently.
- R5: The count (register 2) drops by one per transfer. When it reaches zero the completion flag (control bit 8) is set and `bus_req` goes low.
- R6: `irq` is high exactly while the completion flag and interrupt enable (control bit 1) are both 1.
- R7: With reload off, one request runs the whole job with `bus_req` held continuously, which is 1 + 2·N cycles for N transfers under immediate grant and acknowledge.
- R8: With reload on (control bit 2), after every fourth transfer the source address returns to the value last written to register 0, while the destination keeps stepping.
- R9: With reload on, `bus_req` drops after every fourth transfer, and the channel waits for a new `per_req`.
- R10: While the completion flag is set, `per_req` is ignored. Writing the control register with bit 8 = 0 clears the flag, and writing 1 leaves it unchanged.
- R11: The four-transfer group counter restarts at zero when the enable bit goes from 0 to 1.
- R12: The addresses and count change only when a write beat is acknowledged, not while a transfer is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| per_req | input | 1 | Peripheral data-ready request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | Beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Beat address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Beat completes this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The bound checker checks on every cycle that beats occur only under grant, and that the bus request rises only after a peripheral pulse and falls only after an acknowledged write. It also checks that the addresses and count hold still between acknowledged writes, that a reload boundary snaps the source back and drops the request, and that the interrupt rises only after a completing write or a register write. The directed scenarios are needed to show the address sequences seen on the bus, the exact length of a burst, the split of a reloaded job into two groups under two requests, the effect of the flag-clear bit, and the group counter restarting on enable.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRIDE = DATA_W / 8;

    localparam logic [1:0] REG_SRC  = 2'd0;
    localparam logic [1:0] REG_DST  = 2'd1;
    localparam logic [1:0] REG_CNT  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int BIT_EN     = 0;
    localparam int BIT_IE     = 1;
    localparam int BIT_RELOAD = 2;
    localparam int BIT_DONE   = 8;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_UP    = 2'b01,
        AM_DOWN  = 2'b10,
        AM_KEEP  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARB,
        SQ_RD,
        SQ_WR
    } seq_e;

    typedef struct packed {
        logic   done;
        amode_e dmode;
        amode_e smode;
        logic   reload;
        logic   ie;
        logic   en;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input amode_e m);
        case (m)
            AM_UP:   return a + ADDR_W'(STRIDE);
            AM_DOWN: return a - ADDR_W'(STRIDE);
            default: return a;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_EN]     = c.en;
        w[BIT_IE]     = c.ie;
        w[BIT_RELOAD] = c.reload;
        w[4:3]        = c.smode;
        w[6:5]        = c.dmode;
        w[BIT_DONE]   = c.done;
        return w;
    endfunction

endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int GROUP = 4,
    localparam int GW   = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] sar,
    output logic [ADDR_W-1:0] sar_init,
    output logic [ADDR_W-1:0] dar,
    output logic [CNT_W-1:0]  tcr,
    output ctrl_t             ctrl,
    output logic [GW-1:0]     grp,
    output logic              end_job,
    output logic              end_group,
    output logic              start_ok
);

    logic ctrl_wr;
    assign ctrl_wr   = cfg_we && (cfg_addr == REG_CTRL);
    assign end_job   = (tcr == CNT_W'(1));
    assign end_group = ctrl.reload && (grp == GW'(GROUP - 1));
    assign start_ok  = ctrl.en && !ctrl.done && (tcr != '0);

    always_comb begin
        case (cfg_addr)
            REG_SRC: cfg_rdata = sar;
            REG_DST: cfg_rdata = dar;
            REG_CNT: cfg_rdata = DATA_W'(tcr);
            default: cfg_rdata = ctrl_word(ctrl);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar      <= '0;
            sar_init <= '0;
            dar      <= '0;
            tcr      <= '0;
            ctrl     <= '0;
            grp      <= '0;
        end else begin
            if (xfer_done) begin
                tcr <= tcr - CNT_W'(1);
                dar <= step_addr(dar, ctrl.dmode);
                if (end_group) begin
                    sar <= sar_init;
                    grp <= '0;
                end else begin
                    sar <= step_addr(sar, ctrl.smode);
                    if (ctrl.reload) grp <= grp + 1'b1;
                end
            end
            if (cfg_we) begin
                case (cfg_addr)
                    REG_SRC: begin
                        sar      <= cfg_wdata;
                        sar_init <= cfg_wdata;
                    end
                    REG_DST: dar <= cfg_wdata;
                    REG_CNT: tcr <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        ctrl.en     <= cfg_wdata[BIT_EN];
                        ctrl.ie     <= cfg_wdata[BIT_IE];
                        ctrl.reload <= cfg_wdata[BIT_RELOAD];
                        ctrl.smode  <= amode_e'(cfg_wdata[4:3]);
                        ctrl.dmode  <= amode_e'(cfg_wdata[6:5]);
                        if (cfg_wdata[BIT_EN] && !ctrl.en) grp <= '0;
                    end
                endcase
            end
            if (xfer_done && end_job)
                ctrl.done <= 1'b1;
            else if (ctrl_wr && !cfg_wdata[BIT_DONE])
                ctrl.done <= 1'b0;
        end
    end

endmodule

// File: rtl/dmac_chan_seq.sv
module dmac_chan_seq
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              per_req,
    input  logic              start_ok,
    input  logic              en,
    input  logic              end_job,
    input  logic              end_group,
    input  logic [ADDR_W-1:0] sar,
    input  logic [ADDR_W-1:0] dar,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              xfer_done,
    output seq_e              state
);

    seq_e              nxt;
    logic [DATA_W-1:0] hold_q;
    logic              beat_ok;

    assign beat_ok = bus_gnt && bus_ack;

    always_comb begin
        nxt       = state;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = sar;
        bus_wdata = hold_q;
        xfer_done = 1'b0;
        case (state)
            SQ_IDLE: if (start_ok && per_req) nxt = SQ_ARB;
            SQ_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) nxt = SQ_RD;
            end
            SQ_RD: begin
                bus_req   = 1'b1;
                bus_valid = bus_gnt;
                if (beat_ok) nxt = SQ_WR;
            end
            default: begin
                bus_req   = 1'b1;
                bus_valid = bus_gnt;
                bus_we    = 1'b1;
                bus_addr  = dar;
                if (beat_ok) begin
                    xfer_done = 1'b1;
                    nxt = (end_job || end_group || !en) ? SQ_IDLE : SQ_RD;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            hold_q <= '0;
        end else begin
            state <= nxt;
            if (state == SQ_RD && beat_ok) hold_q <= bus_rdata;
        end
    end

endmodule

// File: rtl/dmac_reload_chan.sv
module dmac_reload_chan
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int GROUP = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        per_req,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        bus_valid,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    output logic        irq
);

    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic [ADDR_W-1:0] sar, sar_init, dar;
    logic [CNT_W-1:0]  tcr;
    ctrl_t             ctrl;
    logic [GW-1:0]     grp;
    logic              end_job, end_group, start_ok, xfer_done;
    seq_e              state;

    dmac_chan_regs #(.CNT_W(CNT_W), .GROUP(GROUP)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xfer_done(xfer_done),
        .sar(sar), .sar_init(sar_init), .dar(dar), .tcr(tcr), .ctrl(ctrl), .grp(grp),
        .end_job(end_job), .end_group(end_group), .start_ok(start_ok)
    );

    dmac_chan_seq u_seq (
        .clk(clk), .rst(rst),
        .per_req(per_req), .start_ok(start_ok), .en(ctrl.en),
        .end_job(end_job), .end_group(end_group),
        .sar(sar), .dar(dar),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .xfer_done(xfer_done), .state(state)
    );

    assign irq = ctrl.done && ctrl.ie;

endmodule

// File: rtl/dmac_reload_chan_chk.sv
module dmac_reload_chan_chk
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int GROUP = 4,
    localparam int GW   = (GROUP > 1) ? $clog2(GROUP) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              per_req,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_valid,
    input logic              bus_we,
    input logic              bus_ack,
    input logic              irq,
    input logic [ADDR_W-1:0] sar,
    input logic [ADDR_W-1:0] sar_init,
    input logic [ADDR_W-1:0] dar,
    input logic [CNT_W-1:0]  tcr,
    input ctrl_t             ctrl,
    input logic [GW-1:0]     grp
);

    logic wr_ack;
    assign wr_ack = bus_valid && bus_we && bus_ack;

    a_r3_valid_granted: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_gnt && bus_req));

    a_r2_req_after_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(per_req));

    a_r7_req_falls_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(wr_ack));

    a_r12_regs_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_ack && !cfg_we) |=> ($stable(sar) && $stable(dar) && $stable(tcr)));

    a_r4_dst_up: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !cfg_we && ctrl.dmode == AM_UP) |=> (dar == $past(dar) + ADDR_W'(STRIDE)));

    a_r8_src_snap: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !cfg_we && ctrl.reload && grp == GW'(GROUP - 1)) |=> (sar == $past(sar_init)));

    a_r9_group_release: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && ctrl.reload && grp == GW'(GROUP - 1)) |=> !bus_req);

    a_r5_done_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.done |-> !bus_valid);

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(wr_ack) || $past(cfg_we)));

endmodule

bind dmac_reload_chan dmac_reload_chan_chk #(.CNT_W(CNT_W), .GROUP(GROUP)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .per_req(per_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_ack(bus_ack), .irq(irq),
    .sar(sar), .sar_init(sar_init), .dar(dar), .tcr(tcr), .ctrl(ctrl), .grp(grp)
);

// File: tb/sim_dmac_reload_chan.sv
`timescale 1ns/1ps
module sim_dmac_reload_chan;

    localparam logic [31:0] MAGIC = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        per_req = 1'b0;
    logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ack, irq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        gnt_en = 1'b1;

    int checks = 0;
    int errors = 0;

    logic [31:0] wa [64];
    logic [31:0] wdv[64];
    logic [31:0] ra [64];
    int wn = 0, rn = 0, rises = 0, req_cyc = 0;
    logic req_prev = 1'b0;

    always #2 clk = ~clk;

    assign bus_gnt   = bus_req & gnt_en;
    assign bus_ack   = bus_valid;
    assign bus_rdata = bus_addr ^ MAGIC;

    dmac_reload_chan u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .per_req(per_req),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .irq(irq)
    );

    always @(negedge clk) begin
        if (bus_valid && bus_ack) begin
            if (bus_we) begin
                if (wn < 64) begin wa[wn] = bus_addr; wdv[wn] = bus_wdata; end
                wn = wn + 1;
            end else begin
                if (rn < 64) ra[rn] = bus_addr;
                rn = rn + 1;
            end
        end
        if (bus_req && !req_prev) rises = rises + 1;
        if (bus_req) req_cyc = req_cyc + 1;
        req_prev = bus_req;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        cfg_addr = a;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic pulse();
        @(posedge clk); #1;
        per_req = 1'b1;
        @(posedge clk); #1;
        per_req = 1'b0;
    endtask

    task automatic clr_log();
        wn = 0; rn = 0; rises = 0; req_cyc = 0;
    endtask

    function automatic logic [31:0] cw(input bit en, input bit ie, input bit rl,
                                       input logic [1:0] sm, input logic [1:0] dm);
        return {23'd0, 1'b0, 1'b0, dm, sm, rl, ie, en};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            cfg_rd(2'(i), v);
            chk(v == 32'd0, "R1 register reset value", v, 32'd0);
        end
        chk(bus_req == 1'b0, "R1 bus_req low", 32'(bus_req), 32'd0);
        chk(irq == 1'b0, "R1 irq low", 32'(irq), 32'd0);
    endtask

    task automatic t_disabled();
        clr_log();
        cfg_wr(2'd2, 32'd3);
        cfg_wr(2'd3, cw(0, 1, 0, 2'b01, 2'b01));
        pulse();
        ticks(20);
        chk(rises == 0, "R2 no request while disabled", 32'(rises), 32'd0);
        chk(wn == 0, "R2 no beats while disabled", 32'(wn), 32'd0);
    endtask

    task automatic t_burst_up_down();
        logic [31:0] v;
        bit ok;
        clr_log();
        cfg_wr(2'd0, 32'h0000_1000);
        cfg_wr(2'd1, 32'h0000_2000);
        cfg_wr(2'd2, 32'd6);
        cfg_wr(2'd3, cw(1, 1, 0, 2'b01, 2'b10));
        pulse();
        ticks(40);
        chk(wn == 6, "R5 six transfers", 32'(wn), 32'd6);
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (ra[k] != 32'h1000 + 32'(4*k)) ok = 1'b0;
            if (wa[k] != 32'h2000 - 32'(4*k)) ok = 1'b0;
            if (wdv[k] != ((32'h1000 + 32'(4*k)) ^ MAGIC)) ok = 1'b0;
        end
        chk(ok, "R3 R4 read/write sequence up/down", wa[5], 32'h0000_1FEC);
        chk(rises == 1, "R7 single bus request", 32'(rises), 32'd1);
        chk(req_cyc == 13, "R7 burst length 1+2N", 32'(req_cyc), 32'd13);
        cfg_rd(2'd0, v); chk(v == 32'h0000_1018, "R4 source stepped up", v, 32'h0000_1018);
        cfg_rd(2'd1, v); chk(v == 32'h0000_1FE8, "R4 destination stepped down", v, 32'h0000_1FE8);
        cfg_rd(2'd2, v); chk(v == 32'd0, "R5 count exhausted", v, 32'd0);
        cfg_rd(2'd3, v); chk(v[8] == 1'b1, "R5 completion flag", 32'(v[8]), 32'd1);
        chk(bus_req == 1'b0, "R5 bus released", 32'(bus_req), 32'd0);
        chk(irq == 1'b1, "R6 irq with enable", 32'(irq), 32'd1);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        bit ok;
        clr_log();
        cfg_wr(2'd3, cw(0, 1, 1, 2'b01, 2'b01));
        chk(irq == 1'b0, "R6 irq cleared with flag", 32'(irq), 32'd0);
        cfg_wr(2'd0, 32'h0000_4000);
        cfg_wr(2'd1, 32'h0000_8000);
        cfg_wr(2'd2, 32'd8);
        cfg_wr(2'd3, cw(1, 1, 1, 2'b01, 2'b01));
        pulse();
        ticks(30);
        chk(wn == 4, "R9 group of four then stop", 32'(wn), 32'd4);
        chk(bus_req == 1'b0, "R9 request dropped between groups", 32'(bus_req), 32'd0);
        cfg_rd(2'd0, v); chk(v == 32'h0000_4000, "R8 source snapped back", v, 32'h0000_4000);
        cfg_rd(2'd1, v); chk(v == 32'h0000_8010, "R8 destination kept stepping", v, 32'h0000_8010);
        cfg_rd(2'd2, v); chk(v == 32'd4, "R5 count after first group", v, 32'd4);
        pulse();
        ticks(30);
        chk(wn == 8, "R9 second group on new request", 32'(wn), 32'd8);
        chk(rises == 2, "R9 one request per group", 32'(rises), 32'd2);
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (ra[k] != 32'h4000 + 32'(4*(k % 4))) ok = 1'b0;
            if (wa[k] != 32'h8000 + 32'(4*k)) ok = 1'b0;
        end
        chk(ok, "R8 reload address sequence", ra[4], 32'h0000_4000);
        chk(irq == 1'b1, "R6 irq at end of reloaded job", 32'(irq), 32'd1);
    endtask

    task automatic t_fixed_noirq();
        logic [31:0] v;
        bit ok;
        clr_log();
        cfg_wr(2'd3, cw(0, 0, 0, 2'b00, 2'b11));
        cfg_wr(2'd0, 32'h0000_0300);
        cfg_wr(2'd1, 32'h0000_0500);
        cfg_wr(2'd2, 32'd3);
        cfg_wr(2'd3, cw(1, 0, 0, 2'b00, 2'b11));
        pulse();
        ticks(20);
        ok = (wn == 3);
        for (int k = 0; k < 3; k++)
            if (ra[k] != 32'h300 || wa[k] != 32'h500) ok = 1'b0;
        chk(ok, "R4 fixed modes hold addresses", wa[2], 32'h0000_0500);
        cfg_rd(2'd3, v);
        chk(v[8] == 1'b1, "R5 flag set", 32'(v[8]), 32'd1);
        chk(irq == 1'b0, "R6 irq masked", 32'(irq), 32'd0);
    endtask

    task automatic t_flag_block();
        logic [31:0] v;
        clr_log();
        cfg_wr(2'd2, 32'd2);
        pulse();
        ticks(15);
        chk(wn == 0 && rises == 0, "R10 request ignored while flag set", 32'(wn), 32'd0);
        cfg_wr(2'd3, cw(1, 0, 0, 2'b00, 2'b11) | 32'h100);
        cfg_rd(2'd3, v);
        chk(v[8] == 1'b1, "R10 writing one keeps flag", 32'(v[8]), 32'd1);
        cfg_wr(2'd3, cw(1, 0, 0, 2'b00, 2'b11));
        cfg_rd(2'd3, v);
        chk(v[8] == 1'b0, "R10 writing zero clears flag", 32'(v[8]), 32'd0);
        pulse();
        ticks(15);
        chk(wn == 2, "R10 restart after clear", 32'(wn), 32'd2);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        clr_log();
        cfg_wr(2'd3, cw(0, 0, 0, 2'b01, 2'b01));
        cfg_wr(2'd0, 32'h0000_0A00);
        cfg_wr(2'd2, 32'd1);
        cfg_wr(2'd3, cw(1, 0, 0, 2'b01, 2'b01));
        gnt_en = 1'b0;
        pulse();
        ticks(10);
        chk(bus_req == 1'b1 && bus_valid == 1'b0, "R3 no beat without grant",
            32'(bus_valid), 32'd0);
        cfg_rd(2'd0, v); chk(v == 32'h0000_0A00, "R12 source held while stalled", v, 32'h0000_0A00);
        cfg_rd(2'd2, v); chk(v == 32'd1, "R12 count held while stalled", v, 32'd1);
        gnt_en = 1'b1;
        ticks(10);
        chk(wn == 1, "R3 transfer after grant", 32'(wn), 32'd1);
        cfg_rd(2'd2, v); chk(v == 32'd0, "R12 count updated after write", v, 32'd0);
    endtask

    task automatic t_group_restart();
        logic [31:0] v;
        clr_log();
        cfg_wr(2'd3, cw(0, 0, 1, 2'b01, 2'b01));
        cfg_wr(2'd0, 32'h0000_0100);
        cfg_wr(2'd1, 32'h0000_0200);
        cfg_wr(2'd2, 32'd2);
        cfg_wr(2'd3, cw(1, 0, 1, 2'b01, 2'b01));
        pulse();
        ticks(15);
        chk(wn == 2, "R11 short reloaded job", 32'(wn), 32'd2);
        clr_log();
        cfg_wr(2'd3, cw(0, 0, 1, 2'b01, 2'b01));
        cfg_wr(2'd0, 32'h0000_0100);
        cfg_wr(2'd2, 32'd8);
        cfg_wr(2'd3, cw(1, 0, 1, 2'b01, 2'b01));
        pulse();
        ticks(25);
        chk(wn == 4, "R11 full group after re-enable", 32'(wn), 32'd4);
        cfg_rd(2'd0, v); chk(v == 32'h0000_0100, "R11 source back at group end", v, 32'h0000_0100);
        cfg_rd(2'd2, v); chk(v == 32'd4, "R11 count after group", v, 32'd4);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        ticks(4);
        rst = 1'b0;
        ticks(2);
        t_reset();
        t_disabled();
        t_burst_up_down();
        t_reload();
        t_fixed_noirq();
        t_flag_block();
        t_stall();
        t_group_restart();
        ticks(5);
        summary();
    end

endmodule